// File: doc/BRIEF.md
# Switch Change Reporter over UART

This block watches four slow switch inputs and reports every change of their value as one printable character on an asynchronous serial line. The switch nibble passes through a synchronizer, is compared against the value last captured, and every difference pushes the new value into a small queue. The transmitter takes values from the queue and sends each as an 8N1 frame. The value zero becomes the character 'A', fifteen becomes 'P', and the values in between map in order to the letters between them.

The bit rate comes from a counter that divides the system clock. With the default settings a 50 MHz clock gives 9600 baud. The end of a frame is tracked by a second shift register that runs alongside the data shift register, not by a state machine. A value that flips and flips back while a frame is still on the wire produces two characters, because both changes wait in the queue. When the queue is full, further changes are lost and a sticky flag records the loss.

Top module: `swrep_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `txLine` is high and both `busy` and `overflow` are low.
- R2: A frame is a low start bit, then eight data bits with the least significant bit first, then a high stop bit, with no parity bit. Whenever `busy` is low, `txLine` is high.
- R3: Every bit lasts `CLKS_PER_BIT` clock cycles (default 5208). The start bit is never shortened, because the bit counter restarts whenever a frame is loaded.
- R4: A switch value v is sent as the byte 0x41 + v, so 0 gives 'A' (0x41) and 15 gives 'P' (0x50).
- R5: If the synchronized switch value equals the value captured last, no character is sent.
- R6: After reset, the synchronized switch value is reported exactly once, even if it never changes.
- R7: `busy` rises in the cycle a frame is loaded and stays high for exactly 10 × `CLKS_PER_BIT` cycles. `busy` is then low for at least one cycle before the next frame is loaded.
- R8: Detected changes wait in a queue of `FIFO_DEPTH` entries (default 4) and are sent in the order they arrived. A value that changes and changes back within one frame time produces both characters.
- R9: A change detected while the queue is full is dropped and sets `overflow`. `overflow` then stays high until reset.
- R10: When the line is idle, a change on `swIn` applied before clock edge 1 reaches the queue at edge `SYNC_STAGES`+1. The frame loads, so that `busy` rises and `txLine` falls, at edge `SYNC_STAGES`+2 (edge 4 with the default two stages).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| swIn | input | 4 | Asynchronous switch inputs |
| txLine | output | 1 | Serial output, idles high |
| busy | output | 1 | High while a frame is being sent |
| overflow | output | 1 | Sticky flag for a change lost because the queue was full |

## Verification
The bench drives `swIn` on falling clock edges and samples the outputs on falling edges, so each result is counted in clock edges after the change. With the default two-stage synchronizer, `busy` must still be low at the third falling edge after a change and high at the fourth (R10). From the load onward, the start bit must be low for exactly `CLKS_PER_BIT` samples and `busy` must be high for exactly ten times that (R3, R7). Characters are recovered by a receiver model in the bench that samples the middle of each bit. Each stimulus therefore waits for the receive count to advance, within a bounded number of cycles, before it compares the byte, and the no-send cases keep checking that count for longer than two frame times.

// File: rtl/swrep_pkg.sv
package swrep_pkg;

  // Start bit + 8 data bits + stop bit
  localparam int FRAME_BITS = 10;
  localparam int NIBBLE_W   = 4;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic loadFrame;  // take queue head and start a new frame
    logic bitTick;    // one bit period has elapsed
  } txStrobe_t;

  // Map a nibble onto the contiguous letters 'A'..'P'
  function automatic logic [7:0] nibbleToChar(input logic [NIBBLE_W-1:0] v);
    return 8'h41 + {4'h0, v};
  endfunction

endpackage

// File: rtl/swrep_fifo.sv
module swrep_fifo #(
  parameter int WIDTH = 4,
  parameter int DEPTH = 4   // power of two
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] wrData,
  input  logic             pop,
  output logic [WIDTH-1:0] rdData,
  output logic             full,
  output logic             empty
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0]      wrPtr;
  logic [AW:0]      rdPtr;
  logic             doPush;
  logic             doPop;

  always_comb begin
    empty  = (wrPtr == rdPtr);
    full   = (wrPtr[AW] != rdPtr[AW]) && (wrPtr[AW-1:0] == rdPtr[AW-1:0]);
    doPush = push && !full;
    doPop  = pop && !empty;
    rdData = mem[rdPtr[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr[AW-1:0]] <= wrData;
  end

endmodule

// File: rtl/swrep_ctrl.sv
module swrep_ctrl
  import swrep_pkg::*;
#(
  parameter int CLKS_PER_BIT = 5208   // at least 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      fifoEmpty,
  output txStrobe_t strobe,
  output logic      busy
);

  localparam int CW = $clog2(CLKS_PER_BIT);
  localparam logic [CW-1:0] LAST_CNT = CW'(CLKS_PER_BIT - 1);

  logic [FRAME_BITS-1:0] busyShift;
  logic [CW-1:0]         bitCnt;

  always_comb begin
    strobe.loadFrame = !busyShift[0] && !fifoEmpty;
    strobe.bitTick   = busyShift[0] && (bitCnt == LAST_CNT);
    busy             = busyShift[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busyShift <= '0;
      bitCnt    <= '0;
    end else if (strobe.loadFrame) begin
      busyShift <= '1;
      bitCnt    <= '0;   // full-length start bit
    end else if (busyShift[0]) begin
      if (strobe.bitTick) begin
        bitCnt    <= '0;
        busyShift <= {1'b0, busyShift[FRAME_BITS-1:1]};
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/swrep_datapath.sv
module swrep_datapath
  import swrep_pkg::*;
#(
  parameter int FIFO_DEPTH  = 4,
  parameter int SYNC_STAGES = 2   // at least 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NIBBLE_W-1:0] swIn,
  input  txStrobe_t           strobe,
  output logic                fifoEmpty,
  output logic                txLine,
  output logic                overflow
);

  localparam int SCW = $clog2(SYNC_STAGES + 1);
  localparam logic [SCW-1:0] SETTLED = SCW'(SYNC_STAGES);

  logic [SYNC_STAGES-1:0][NIBBLE_W-1:0] syncPipe;
  logic [NIBBLE_W-1:0]   swSync;
  logic [NIBBLE_W-1:0]   lastVal;
  logic [SCW-1:0]        settleCnt;
  logic                  primed;
  logic                  changeSeen;
  logic                  fifoFull;
  logic [NIBBLE_W-1:0]   headVal;
  logic [FRAME_BITS-1:0] dataShift;

  // Synchronizer chain
  always_ff @(posedge clk) begin
    if (rst) begin
      syncPipe <= '0;
    end else begin
      syncPipe[0] <= swIn;
      for (int i = 1; i < SYNC_STAGES; i++) syncPipe[i] <= syncPipe[i-1];
    end
  end

  assign swSync = syncPipe[SYNC_STAGES-1];

  // Change detection; first report once the chain holds live data
  always_comb changeSeen = primed ? (swSync != lastVal) : (settleCnt == SETTLED);

  always_ff @(posedge clk) begin
    if (rst) begin
      settleCnt <= '0;
      primed    <= 1'b0;
      lastVal   <= '0;
    end else begin
      if (settleCnt != SETTLED) settleCnt <= settleCnt + 1'b1;
      if (changeSeen) begin
        primed  <= 1'b1;
        lastVal <= swSync;
      end
    end
  end

  swrep_fifo #(.WIDTH(NIBBLE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk    (clk),
    .rst    (rst),
    .push   (changeSeen),
    .wrData (swSync),
    .pop    (strobe.loadFrame),
    .rdData (headVal),
    .full   (fifoFull),
    .empty  (fifoEmpty)
  );

  always_ff @(posedge clk) begin
    if (rst)                          overflow <= 1'b0;
    else if (changeSeen && fifoFull)  overflow <= 1'b1;
  end

  // Frame shift register: stop, data, start
  always_ff @(posedge clk) begin
    if (rst)                   dataShift <= '1;
    else if (strobe.loadFrame) dataShift <= {1'b1, nibbleToChar(headVal), 1'b0};
    else if (strobe.bitTick)   dataShift <= {1'b1, dataShift[FRAME_BITS-1:1]};
  end

  assign txLine = dataShift[0];

endmodule

// File: rtl/swrep_top.sv
module swrep_top
  import swrep_pkg::*;
#(
  parameter int CLKS_PER_BIT = 5208,
  parameter int FIFO_DEPTH   = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] swIn,
  output logic       txLine,
  output logic       busy,
  output logic       overflow
);

  txStrobe_t strobe;
  logic      fifoEmpty;

  swrep_ctrl #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .fifoEmpty (fifoEmpty),
    .strobe    (strobe),
    .busy      (busy)
  );

  swrep_datapath #(.FIFO_DEPTH(FIFO_DEPTH), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .swIn      (swIn),
    .strobe    (strobe),
    .fifoEmpty (fifoEmpty),
    .txLine    (txLine),
    .overflow  (overflow)
  );

endmodule

// File: rtl/swrep_chk.sv
module swrep_chk #(
  parameter int CLKS_PER_BIT = 5208
) (
  input logic clk,
  input logic rst,
  input logic txLine,
  input logic busy,
  input logic overflow
);

  localparam int FRAME_CYC = 10 * CLKS_PER_BIT;

  int busyLen;

  always_ff @(posedge clk) begin
    if (rst)       busyLen <= 0;
    else if (busy) busyLen <= busyLen + 1;
    else           busyLen <= 0;
  end

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst) !busy |-> txLine); // R2
  AST_START_LOW: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> !txLine); // R2
  AST_FRAME_LEN: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> busyLen == FRAME_CYC); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst) $past(overflow) |-> overflow); // R9

endmodule

bind swrep_top swrep_chk #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .txLine   (txLine),
  .busy     (busy),
  .overflow (overflow)
);

// File: tb/tb_swrep_top.sv
module tb_swrep_top;

  localparam int CPB = 16;
  localparam int NV  = 5;
  // {switch value, expected byte}
  localparam logic [11:0] VEC [NV] = '{
    {4'd3,  8'h44}, {4'd9, 8'h4A}, {4'd15, 8'h50}, {4'd0, 8'h41}, {4'd10, 8'h4B}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] swIn = 4'd4;
  logic       txLine, busy, overflow;

  int checkCnt = 0;
  int failCnt  = 0;
  int rxCount  = 0;
  logic [7:0] rxBuf  [64];
  logic       rxStop [64];

  always #5 clk = ~clk;

  swrep_top #(.CLKS_PER_BIT(CPB)) dut (
    .clk(clk), .rst(rst), .swIn(swIn),
    .txLine(txLine), .busy(busy), .overflow(overflow)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Receiver model: samples the middle of each bit on falling edges
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && txLine === 1'b0) begin
        logic [7:0] b;
        repeat (CPB/2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
          repeat (CPB) @(negedge clk);
          b[i] = txLine;
        end
        repeat (CPB) @(negedge clk);
        if (rxCount < 64) begin
          rxBuf[rxCount]  = b;
          rxStop[rxCount] = txLine;
        end
        rxCount++;
      end
    end
  end

  task automatic waitRx(input int target, input int maxCyc);
    for (int i = 0; i < maxCyc && rxCount < target; i++) @(negedge clk);
  endtask

  task automatic setSw(input logic [3:0] v, input int hold);
    swIn = v;
    repeat (hold) @(negedge clk);
  endtask

  initial begin
    #(1_000_000);
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    int base, lowRun, busyRun;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 txLine", txLine, 1);
    check("R1 busy", busy, 0);
    check("R1 overflow", overflow, 0);
    rst = 1'b0;                       // released at falling edge n0
    @(negedge clk);
    check("R1 txLine after release", txLine, 1);
    repeat (2) @(negedge clk);        // n3
    check("R10 busy still low at edge 3", busy, 0);
    @(negedge clk);                   // n4
    check("R10 busy high at edge 4", busy, 1);
    check("R10 start bit on line", txLine, 0);
    // R3 / R7: start bit and busy width
    lowRun = 0; busyRun = 0;
    while (txLine === 1'b0) begin lowRun++; busyRun++; @(negedge clk); end
    check("R3 start bit length", lowRun, CPB);
    while (busy === 1'b1) begin busyRun++; @(negedge clk); end
    check("R7 busy width", busyRun, 10*CPB);
    waitRx(1, 100);
    // R6: initial value 4 sent once as 'E'
    check("R6 initial report count", rxCount, 1);
    check("R6 initial char", rxBuf[0], 8'h45);
    check("R2 stop bit", rxStop[0], 1);

    // R4 / R2: table of values
    for (int k = 0; k < NV; k++) begin
      base = rxCount;
      setSw(VEC[k][11:8], 1);
      waitRx(base + 1, 20*CPB);
      check($sformatf("R4 char for %0d", VEC[k][11:8]), rxBuf[base], VEC[k][7:0]);
      check("R2 stop bit", rxStop[base], 1);
    end
    repeat (2*CPB) @(negedge clk);

    // R5: same value again produces nothing
    base = rxCount;
    setSw(4'd10, 25*CPB);
    check("R5 no char on unchanged value", rxCount, base);
    check("R5 line idle", txLine, 1);

    // R8: short toggle 10 -> 2 -> 10 gives two chars
    base = rxCount;
    setSw(4'd2, 6);
    setSw(4'd10, 1);
    waitRx(base + 2, 40*CPB);
    check("R8 toggle count", rxCount, base + 2);
    check("R8 first char", rxBuf[base], 8'h43);
    check("R8 second char", rxBuf[base+1], 8'h4B);
    repeat (2*CPB) @(negedge clk);

    // R9: burst of seven changes overflows a 4-deep queue
    check("R9 overflow clear before burst", overflow, 0);
    base = rxCount;
    for (int v = 1; v <= 7; v++) setSw(v[3:0], 4);
    check("R9 overflow set", overflow, 1);
    waitRx(base + 5, 60*CPB);
    repeat (25*CPB) @(negedge clk);
    check("R9 five chars only", rxCount, base + 5);
    for (int j = 0; j < 5; j++)
      check("R8 order kept", rxBuf[base+j], 8'h42 + j);
    check("R9 overflow sticky", overflow, 1);

    // R1 / R6: reset clears the flag, new value reported once
    @(negedge clk);
    rst = 1'b1;
    swIn = 4'd7;
    @(negedge clk);
    check("R1 overflow cleared", overflow, 0);
    check("R1 busy in reset", busy, 0);
    check("R1 txLine in reset", txLine, 1);
    base = rxCount;
    @(negedge clk);
    rst = 1'b0;
    repeat (30*CPB) @(negedge clk);
    check("R6 one report after reset", rxCount, base + 1);
    check("R6 report char", rxBuf[base], 8'h48);

    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule